// File: doc/BRIEF.md
# Wall-Following Robot Controller

This block steers a maze-walking robot that keeps its right feeler pressed against a wall. It reads two contact feelers, one on the left and one on the right. Each feeler reads 1 while it touches something. It drives three motion commands: a forward step, a small left turn and a small right turn. It is a four-state Moore machine, so the commands depend only on the current state.

The state register advances only on clock edges where `step_en` is 1. This lets the surrounding system pace the machine to the robot's motion. A synchronous active-high reset returns the machine to its search state.

The next-state and command logic comes in two variants, chosen by the parameter `IMPL_SEL`:
- A value of 0 selects direct logic equations.
- A value of 1 selects a 16-word by 5-bit lookup table. The table is addressed by the current state followed by the left and right feeler bits.

Both variants must behave identically.

Top module: `wallbot_ctrl`

## Requirements
- R1: Reset is synchronous and active high. On the first edge where `rst` is 1, the state becomes Search (code 00). This takes effect whatever `step_en` is, and after it the commands read fwd=1, turn_l=0, turn_r=0.
- R2: On an edge where `rst` is 0 and `step_en` is 0, the state and all three commands keep their values, whatever the feelers read.
- R3: The state codes are Search=00, Spin=01, HugA=10, HugB=11. The commands depend only on the state, as follows:

  | State | fwd | turn_l | turn_r |
  |---|---|---|---|
  | Search | 1 | 0 | 0 |
  | Spin | 0 | 1 | 0 |
  | HugA | 1 | 0 | 1 |
  | HugB | 1 | 1 | 0 |

- R4: In Search, a stepped edge moves to Spin if either feeler is 1. It stays in Search if both feelers are 0.
- R5: In Spin, a stepped edge stays in Spin while either feeler is 1. It moves to HugA when both feelers are 0.
- R6: In HugA, a stepped edge moves to HugB when the right feeler is 1 and stays in HugA when it is 0. The left feeler has no effect in this state.
- R7: In HugB, a stepped edge behaves as follows. It moves to Spin when the left feeler is 1. It moves to HugA when both feelers are 0. It stays in HugB when only the right feeler is 1.
- R8: Both settings of `IMPL_SEL` give the same state and the same commands, cycle for cycle, for every input sequence.
- R9: `turn_l` and `turn_r` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to Search |
| step_en | input | 1 | Advances the state on this edge when 1 |
| sense_l | input | 1 | Left feeler, 1 when touching |
| sense_r | input | 1 | Right feeler, 1 when touching |
| state_o | output | 2 | Current state code |
| fwd | output | 1 | Forward-step command |
| turn_l | output | 1 | Small left-turn command |
| turn_r | output | 1 | Small right-turn command |

## Verification
The bench drives two instances, one built from equations and one from the table, with the same inputs. It compares both against a behavioural model on every clock, so a single wrong table word or a mistyped equation term shows up as a divergence.

Several corner cases get explicit attention:
- In HugA the left feeler is toggled while the right feeler is 0. A design that decodes the left feeler there would wrongly leave HugA.
- In HugB both feelers are raised together. A design that gives the right feeler priority over the left would stay in HugB instead of spinning.
- Reset is asserted while `step_en` is 0. A design that gates reset with the enable would keep its old state.
- Steps are withheld in every state. A design whose enable leaks would drift.

// File: rtl/wallbot_pkg.sv
package wallbot_pkg;

   localparam int WB_STATE_W = 2;
   localparam int WB_SENSE_W = 2;
   localparam int WB_CMD_W   = 3;
   localparam int WB_WORD_W  = WB_STATE_W + WB_CMD_W;
   localparam int WB_ADDR_W  = WB_STATE_W + WB_SENSE_W;
   localparam int WB_DEPTH   = 1 << WB_ADDR_W;

   typedef enum logic [WB_STATE_W-1:0] {
      ST_SEARCH = 2'b00,
      ST_SPIN   = 2'b01,
      ST_HUGA   = 2'b10,
      ST_HUGB   = 2'b11
   } wb_state_e;

   typedef struct packed {
      logic tr;
      logic tl;
      logic fw;
   } wb_cmd_t;

   // Table word layout: {next_state[1:0], tr, tl, fw}
   // Address layout:    {state[1:0], left, right}
   function automatic logic [WB_WORD_W-1:0] wb_word(input logic [WB_ADDR_W-1:0] adr);
      logic      lf;
      logic      rf;
      wb_state_e nx;
      wb_cmd_t   cm;
      lf = adr[1];
      rf = adr[0];
      nx = ST_SEARCH;
      cm = '0;
      case (wb_state_e'(adr[WB_ADDR_W-1 -: WB_STATE_W]))
         ST_SEARCH: begin
            cm.fw = 1'b1;
            nx    = (lf || rf) ? ST_SPIN : ST_SEARCH;
         end
         ST_SPIN: begin
            cm.tl = 1'b1;
            nx    = (lf || rf) ? ST_SPIN : ST_HUGA;
         end
         ST_HUGA: begin
            cm.tr = 1'b1;
            cm.fw = 1'b1;
            nx    = rf ? ST_HUGB : ST_HUGA;
         end
         default: begin
            cm.tl = 1'b1;
            cm.fw = 1'b1;
            if (lf)      nx = ST_SPIN;
            else if (rf) nx = ST_HUGB;
            else         nx = ST_HUGA;
         end
      endcase
      return {nx, cm};
   endfunction

endpackage

// File: rtl/wallbot_state_reg.sv
module wallbot_state_reg #(
   parameter int W = 2,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)     q <= INIT;
      else if (en) q <= d;
   end

endmodule

// File: rtl/wallbot_eqn.sv
module wallbot_eqn
   import wallbot_pkg::*;
(
   input  logic [WB_STATE_W-1:0] cur,
   input  logic                  lf,
   input  logic                  rf,
   output logic [WB_STATE_W-1:0] nxt,
   output wb_cmd_t               cmd
);

   logic s1, s0, any_touch, hug_a;

   always_comb begin
      s1        = cur[1];
      s0        = cur[0];
      any_touch = lf | rf;
      hug_a     = s1 & ~s0;
      nxt[1]    = hug_a | (s1 & ~lf) | (s0 & ~lf & ~rf);
      nxt[0]    = (any_touch & ~hug_a) | (hug_a & rf);
      cmd.tr    = hug_a;
      cmd.tl    = s0;
      cmd.fw    = s1 | ~s0;
   end

endmodule

// File: rtl/wallbot_rom.sv
module wallbot_rom
   import wallbot_pkg::*;
(
   input  logic [WB_STATE_W-1:0] cur,
   input  logic                  lf,
   input  logic                  rf,
   output logic [WB_STATE_W-1:0] nxt,
   output wb_cmd_t               cmd
);

   logic [WB_WORD_W-1:0] rom [WB_DEPTH];
   logic [WB_ADDR_W-1:0] adr;
   logic [WB_WORD_W-1:0] word;

   for (genvar a = 0; a < WB_DEPTH; a++) begin : g_word
      assign rom[a] = wb_word(WB_ADDR_W'(a));
   end

   always_comb begin
      adr  = {cur, lf, rf};
      word = rom[adr];
      nxt  = word[WB_WORD_W-1 -: WB_STATE_W];
      cmd  = wb_cmd_t'(word[WB_CMD_W-1:0]);
   end

endmodule

// File: rtl/wallbot_ctrl.sv
module wallbot_ctrl
   import wallbot_pkg::*;
#(
   parameter int IMPL_SEL = 0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  step_en,
   input  logic                  sense_l,
   input  logic                  sense_r,
   output logic [WB_STATE_W-1:0] state_o,
   output logic                  fwd,
   output logic                  turn_l,
   output logic                  turn_r
);

   if (IMPL_SEL < 0 || IMPL_SEL > 1) begin : g_bad_impl
      $error("wallbot_ctrl: IMPL_SEL must be 0 or 1");
   end
   if (WB_DEPTH != (1 << (WB_STATE_W + WB_SENSE_W))) begin : g_bad_depth
      $error("wallbot_ctrl: table depth does not match address width");
   end

   logic [WB_STATE_W-1:0] cur, nxt;
   wb_cmd_t               cmd;

   wallbot_state_reg #(.W(WB_STATE_W), .INIT(ST_SEARCH)) u_state (
      .clk (clk),
      .rst (rst),
      .en  (step_en),
      .d   (nxt),
      .q   (cur)
   );

   if (IMPL_SEL == 1) begin : g_table
      wallbot_rom u_logic (
         .cur (cur),
         .lf  (sense_l),
         .rf  (sense_r),
         .nxt (nxt),
         .cmd (cmd)
      );
   end else begin : g_eqn
      wallbot_eqn u_logic (
         .cur (cur),
         .lf  (sense_l),
         .rf  (sense_r),
         .nxt (nxt),
         .cmd (cmd)
      );
   end

   assign state_o = cur;
   assign fwd     = cmd.fw;
   assign turn_l  = cmd.tl;
   assign turn_r  = cmd.tr;

endmodule

// File: rtl/wallbot_chk.sv
module wallbot_chk (
   input logic       clk,
   input logic       rst,
   input logic       step_en,
   input logic       sense_l,
   input logic       sense_r,
   input logic [1:0] state_o,
   input logic       fwd,
   input logic       turn_l,
   input logic       turn_r
);

   // R1
   reset_entry_chk: assert property (@(posedge clk) rst |=> (state_o == 2'b00));

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> ($stable(state_o) && $stable(fwd)));

   // R3
   search_cmd_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == 2'b00) |-> (fwd && !turn_l && !turn_r));

   // R4
   search_stay_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && state_o == 2'b00 && !sense_l && !sense_r) |=> (state_o == 2'b00));

   // R6
   huga_ignores_left_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && state_o == 2'b10 && !sense_r) |=> (state_o == 2'b10));

   // R7
   hugb_left_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && state_o == 2'b11 && sense_l) |=> (state_o == 2'b01));

   // R9
   turn_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({turn_l, turn_r}));

endmodule

bind wallbot_ctrl wallbot_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .step_en (step_en),
   .sense_l (sense_l),
   .sense_r (sense_r),
   .state_o (state_o),
   .fwd     (fwd),
   .turn_l  (turn_l),
   .turn_r  (turn_r)
);

// File: tb/sim_wallbot_ctrl.sv
module sim_wallbot_ctrl;

   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       step_en = 1'b0;
   logic       sense_l = 1'b0;
   logic       sense_r = 1'b0;
   logic [1:0] st0, st1;
   logic       f0, f1, tl0, tl1, tr0, tr1;

   int total  = 0;
   int failed = 0;
   bit done   = 0;
   int model  = 0;
   string tag = "R1";

   always #(PERIOD/2) clk = ~clk;

   wallbot_ctrl #(.IMPL_SEL(0)) u0 (
      .clk(clk), .rst(rst), .step_en(step_en), .sense_l(sense_l), .sense_r(sense_r),
      .state_o(st0), .fwd(f0), .turn_l(tl0), .turn_r(tr0));

   wallbot_ctrl #(.IMPL_SEL(1)) u1 (
      .clk(clk), .rst(rst), .step_en(step_en), .sense_l(sense_l), .sense_r(sense_r),
      .state_o(st1), .fwd(f1), .turn_l(tl1), .turn_r(tr1));

   // Behavioural reference: Search=0, Spin=1, HugA=2, HugB=3
   function automatic int ref_next(int s, bit l, bit r);
      if (s == 0) return (l || r) ? 1 : 0;
      if (s == 1) return (l || r) ? 1 : 2;
      if (s == 2) return r ? 3 : 2;
      if (l) return 1;
      return r ? 3 : 2;
   endfunction

   // returns {fwd, turn_l, turn_r}
   function automatic logic [2:0] ref_cmd(int s);
      case (s)
         0: return 3'b100;
         1: return 3'b010;
         2: return 3'b101;
         default: return 3'b110;
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         failed++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // At a falling edge: compare both instances with the model.
   task automatic compare();
      check(tag, int'(st0), model);
      check({tag, " (R3 cmd)"}, int'({f0, tl0, tr0}), int'(ref_cmd(model)));
      check("R8 state", int'(st1), int'(st0));
      check("R8 cmd", int'({f1, tl1, tr1}), int'({f0, tl0, tr0}));
      check("R9", int'(tl0 & tr0), 0);
   endtask

   // Drive inputs at a falling edge, advance the model, then compare at the next falling edge.
   task automatic step(bit r_in, bit en, bit l, bit r);
      rst = r_in; step_en = en; sense_l = l; sense_r = r;
      if (r_in)       tag = "R1";
      else if (!en)   tag = "R2";
      else if (model == 0) tag = "R4";
      else if (model == 1) tag = "R5";
      else if (model == 2) tag = "R6";
      else                 tag = "R7";
      if (r_in)     model = 0;
      else if (en)  model = ref_next(model, l, r);
      @(negedge clk);
      compare();
   endtask

   initial begin
      @(negedge clk);
      step(1, 0, 0, 0);
      // R1: reset state
      check("R1 reset state", int'(st0), 0);
      check("R1 reset cmd", int'({f0, tl0, tr0}), 3'b100);
      // R4: stay, then touch
      step(0, 1, 0, 0);
      step(0, 1, 0, 1);
      // R5: stay while touching, leave when clear
      step(0, 1, 1, 0);
      step(0, 1, 1, 1);
      step(0, 1, 0, 0);
      // R6: left toggles ignored in HugA
      step(0, 1, 1, 0);
      step(0, 1, 1, 0);
      step(0, 1, 0, 1);
      // R7: only right stays, both -> Spin
      step(0, 1, 0, 1);
      step(0, 1, 1, 1);
      step(0, 1, 0, 0);
      step(0, 1, 0, 1);
      step(0, 1, 0, 0);
      // R2: withheld steps in HugA with touching feelers
      step(0, 0, 1, 1);
      step(0, 0, 0, 1);
      // R1: reset while step_en low
      step(1, 0, 1, 1);
      check("R1 reset without step", int'(st0), 0);
      // random sweep
      for (int i = 0; i < 3000; i++) begin
         int rv;
         rv = int'($urandom_range(0, 99));
         step(rv < 2, rv >= 2 && rv < 85, 1'($urandom), 1'($urandom));
      end
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         total++;
         failed++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

endmodule